// File: doc/BRIEF.md
# Asynchronous Memory Read-Cycle Controller

This block runs single read accesses to an external asynchronous device, such as a static RAM or a character display module, over a 24-bit address bus and an 8-bit data bus. An internal master raises a request with an address. The controller then drives two active-low strobes: a device select and a read enable. Each strobe has its own setup count and its own pulse count, both in clock cycles. A shared cycle count sets how long the whole access lasts. The address is held on the bus for the whole access.

The two strobe waveforms are independent, and the controller never compares their timings. A single mode input names the strobe whose rising edge marks the data capture point. The read byte is sampled on the clock edge that produces that rise. When the cycle count has elapsed, a one-clock acknowledge returns the captured byte. A zero pulse or cycle length is illegal. The block runs it as one clock and sets a sticky error flag.

Top module: `amem_read_ctrl`

## Requirements
- R1: After reset both strobes are high (1), and `req_ack`, `busy` and `cfg_err` are 0.
- R2: A request is accepted on a rising clock edge where `req_valid` is 1, `busy` is 0 and `req_ack` is 0. From the next clock period `mem_addr` shows the request address, and it stays unchanged while `busy` is 1.
- R3: Number the busy clock periods p = 0, 1, ... with p = 0 being the period right after acceptance. A strobe is low (0) in period p exactly when setup <= p < setup + pulse and p < cycle count. In every other period, including every period with `busy` at 0, it is high.
- R4: `busy` is 1 for exactly cycle-count periods. In the following period `req_ack` is 1 for one period only, and `busy` is 0 in that period.
- R5: With `cfg_cap_on_rd` = 1, `ack_data` is the value on `mem_data_in` during the last low period of the read strobe. This is the value sampled at the edge that raises that strobe, whatever the select strobe does.
- R6: With `cfg_cap_on_rd` = 0, `ack_data` is the value on `mem_data_in` during the last low period of the select strobe, whatever the read strobe does.
- R7: If setup + pulse of a strobe exceeds the cycle count, that strobe is driven high at the edge that ends the access. When it is the selected strobe, data is captured at that edge.
- R8: If the selected strobe is never low during an access, `ack_data` is 0x00.
- R9: A pulse or cycle count of 0 behaves as 1. Any accepted access that uses a zero value sets `cfg_err` to 1. `cfg_err` then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request from the internal master |
| req_addr | input | 24 | Address of the requested byte |
| req_ack | output | 1 | One-clock completion pulse |
| ack_data | output | 8 | Captured byte, valid with `req_ack` and held afterwards |
| busy | output | 1 | Access in progress |
| cfg_cs_setup | input | CNT_W | Clocks from access start to select strobe falling |
| cfg_cs_pulse | input | CNT_W | Clocks the select strobe stays low |
| cfg_rd_setup | input | CNT_W | Clocks from access start to read strobe falling |
| cfg_rd_pulse | input | CNT_W | Clocks the read strobe stays low |
| cfg_cycle | input | CNT_W | Total access length in clocks |
| cfg_cap_on_rd | input | 1 | 1: read strobe rise captures data; 0: select strobe rise captures |
| cfg_err | output | 1 | Sticky zero-length configuration flag |
| mem_addr | output | 24 | External address bus |
| mem_data_in | input | 8 | External data bus |
| mem_cs_n | output | 1 | Device select strobe, active low |
| mem_rd_n | output | 1 | Read enable strobe, active low |

## Verification
The hardest case to reach is a capture point that differs from the other strobe's rise. In that case the device drives a valid byte only late in the selected strobe's pulse, and the bus is floating at the other strobe's edge. The bench models a device that floats the bus (0xEE) until the selected strobe has been low for two clocks. It then programs waveforms where the non-selected strobe rises first, rises last, or runs past the cycle end. A one-clock selected pulse must return the float value, so a capture made one edge early or late shows up as a different byte. Back-to-back requests with `req_valid` held high check the idle gap after the acknowledge.

// File: rtl/amem_rd_pkg.sv
// Package: shared widths and the capture-select encoding of the
// asynchronous read controller. Assumes nothing beyond IEEE 1800-2017.
package amem_rd_pkg;
    localparam int ADDR_W = 24;
    localparam int DATA_W = 8;
    localparam int NUM_STROBES = 2;
    localparam int STB_CS = 0;
    localparam int STB_RD = 1;

    typedef enum logic {
        CAP_ON_CS = 1'b0,
        CAP_ON_RD = 1'b1
    } cap_sel_e;
endpackage

// File: rtl/amem_cycle_seq.sv
// Module: access sequencer. Counts clock periods of one access and
// reports the next-state count, so that strobe registers can be
// computed one edge ahead. Assumes cycle_len_i is stable while busy.
module amem_cycle_seq #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] cycle_len_i,
    output logic             busy_o,
    output logic             busy_nxt_o,
    output logic [CNT_W-1:0] cnt_nxt_o,
    output logic             done_o,
    output logic             zero_len_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic [CNT_W-1:0] len_eff;
    logic             last;

    // Clamp a zero length to one clock and detect the final period.
    always_comb begin
        zero_len_o = (cycle_len_i == '0);
        len_eff    = zero_len_o ? CNT_W'(1) : cycle_len_i;
        last       = busy_q && (({1'b0, cnt_q} + (CNT_W+1)'(1)) >= {1'b0, len_eff});
        busy_nxt_o = start_i || (busy_q && !last);
        if (start_i)
            cnt_nxt_o = '0;
        else if (busy_q && !last)
            cnt_nxt_o = cnt_q + CNT_W'(1);
        else
            cnt_nxt_o = '0;
        done_o = last;
    end

    // Hold the period counter and busy state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_nxt_o;
            busy_q <= busy_nxt_o;
        end
    end

    assign busy_o = busy_q;

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> ({1'b0, cnt_q} < {1'b0, len_eff})); // R4
endmodule

// File: rtl/amem_strobe_gen.sv
// Module: one active-low strobe. Decides from the next-state period
// count whether the strobe is low in the coming period and registers
// that, giving glitch-free outputs. Assumes setup/pulse stable while busy.
module amem_strobe_gen #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_nxt_i,
    input  logic [CNT_W-1:0] cnt_nxt_i,
    input  logic [CNT_W-1:0] setup_i,
    input  logic [CNT_W-1:0] pulse_i,
    output logic             strobe_n_o,
    output logic             asrt_nxt_o,
    output logic             zero_pulse_o
);
    logic [CNT_W-1:0] pulse_eff;
    logic [CNT_W:0]   win_end;

    // Compute the low window for the next period.
    always_comb begin
        zero_pulse_o = (pulse_i == '0);
        pulse_eff    = zero_pulse_o ? CNT_W'(1) : pulse_i;
        win_end      = {1'b0, setup_i} + {1'b0, pulse_eff};
        asrt_nxt_o   = run_nxt_i && (cnt_nxt_i >= setup_i) && ({1'b0, cnt_nxt_i} < win_end);
    end

    // Register the strobe level (high in reset).
    always_ff @(posedge clk) begin
        if (!rst_n)
            strobe_n_o <= 1'b1;
        else
            strobe_n_o <= !asrt_nxt_o;
    end
endmodule

// File: rtl/amem_read_ctrl.sv
// Module: asynchronous memory read-cycle controller (top). Accepts a
// request, runs two independently timed strobes, captures the data byte
// at the rising edge of the strobe picked by cfg_cap_on_rd and returns
// it with a one-clock acknowledge. Assumes configuration inputs are
// held stable while busy is high.
module amem_read_ctrl
    import amem_rd_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ack,
    output logic [DATA_W-1:0] ack_data,
    output logic              busy,
    input  logic [CNT_W-1:0]  cfg_cs_setup,
    input  logic [CNT_W-1:0]  cfg_cs_pulse,
    input  logic [CNT_W-1:0]  cfg_rd_setup,
    input  logic [CNT_W-1:0]  cfg_rd_pulse,
    input  logic [CNT_W-1:0]  cfg_cycle,
    input  logic              cfg_cap_on_rd,
    output logic              cfg_err,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_data_in,
    output logic              mem_cs_n,
    output logic              mem_rd_n
);
    logic              start;
    logic              busy_nxt;
    logic [CNT_W-1:0]  cnt_nxt;
    logic              done;
    logic              zero_cycle;
    logic [CNT_W-1:0]  setup_a  [NUM_STROBES];
    logic [CNT_W-1:0]  pulse_a  [NUM_STROBES];
    logic              stb_n    [NUM_STROBES];
    logic              asrt_nxt [NUM_STROBES];
    logic              zero_p   [NUM_STROBES];
    logic              sel_now;
    logic              sel_nxt;
    logic              cap_fire;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] cap_q;
    logic [DATA_W-1:0] ack_data_q;
    logic              ack_q;
    logic              err_q;
    cap_sel_e          cap_sel;

    // Accept only when idle and not in the acknowledge period.
    assign start = req_valid && !busy && !ack_q;

    amem_cycle_seq #(.CNT_W(CNT_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .cycle_len_i (cfg_cycle),
        .busy_o      (busy),
        .busy_nxt_o  (busy_nxt),
        .cnt_nxt_o   (cnt_nxt),
        .done_o      (done),
        .zero_len_o  (zero_cycle)
    );

    // Route per-strobe timing into arrays for the generate loop.
    always_comb begin
        setup_a[STB_CS] = cfg_cs_setup;
        pulse_a[STB_CS] = cfg_cs_pulse;
        setup_a[STB_RD] = cfg_rd_setup;
        pulse_a[STB_RD] = cfg_rd_pulse;
    end

    for (genvar g = 0; g < NUM_STROBES; g++) begin : g_stb
        amem_strobe_gen #(.CNT_W(CNT_W)) u_stb (
            .clk          (clk),
            .rst_n        (rst_n),
            .run_nxt_i    (busy_nxt),
            .cnt_nxt_i    (cnt_nxt),
            .setup_i      (setup_a[g]),
            .pulse_i      (pulse_a[g]),
            .strobe_n_o   (stb_n[g]),
            .asrt_nxt_o   (asrt_nxt[g]),
            .zero_pulse_o (zero_p[g])
        );
    end

    // Pick the capture strobe; fire on the edge that raises it.
    always_comb begin
        cap_sel  = cap_sel_e'(cfg_cap_on_rd);
        sel_now  = (cap_sel == CAP_ON_RD) ? !stb_n[STB_RD] : !stb_n[STB_CS];
        sel_nxt  = (cap_sel == CAP_ON_RD) ? asrt_nxt[STB_RD] : asrt_nxt[STB_CS];
        cap_fire = sel_now && !sel_nxt;
    end

    // Latch the address, capture data and build the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q     <= '0;
            cap_q      <= '0;
            ack_data_q <= '0;
            ack_q      <= 1'b0;
        end else begin
            if (start) begin
                addr_q <= req_addr;
                cap_q  <= '0;
            end else if (cap_fire) begin
                cap_q  <= mem_data_in;
            end
            if (done)
                ack_data_q <= cap_fire ? mem_data_in : cap_q;
            ack_q <= done;
        end
    end

    // Sticky flag for zero pulse or cycle lengths used by an access.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (start && (zero_cycle || zero_p[STB_CS] || zero_p[STB_RD]))
            err_q <= 1'b1;
    end

    assign req_ack  = ack_q;
    assign ack_data = ack_data_q;
    assign cfg_err  = err_q;
    assign mem_addr = addr_q;
    assign mem_cs_n = stb_n[STB_CS];
    assign mem_rd_n = stb_n[STB_RD];

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mem_addr)); // R2
    AST_STROBES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mem_cs_n && mem_rd_n)); // R3
    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack); // R4
    AST_ACK_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> (!busy && $past(busy))); // R4
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err); // R9
endmodule

// File: tb/amem_read_ctrl_test.sv
// Bench: scoreboard. The driver pushes expected results, the monitor
// pops and compares on each acknowledge. A device model drives valid
// data once the selected strobe has been low for two clocks.
module amem_read_ctrl_test;
    localparam int CNT_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [23:0]      req_addr = '0;
    logic             req_ack;
    logic [7:0]       ack_data;
    logic             busy;
    logic [CNT_W-1:0] cfg_cs_setup = '0;
    logic [CNT_W-1:0] cfg_cs_pulse = CNT_W'(1);
    logic [CNT_W-1:0] cfg_rd_setup = '0;
    logic [CNT_W-1:0] cfg_rd_pulse = CNT_W'(1);
    logic [CNT_W-1:0] cfg_cycle = CNT_W'(2);
    logic             cfg_cap_on_rd = 1'b1;
    logic             cfg_err;
    logic [23:0]      mem_addr;
    logic [7:0]       mem_data_in = 8'hEE;
    logic             mem_cs_n;
    logic             mem_rd_n;

    amem_read_ctrl #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ack(req_ack), .ack_data(ack_data), .busy(busy),
        .cfg_cs_setup(cfg_cs_setup), .cfg_cs_pulse(cfg_cs_pulse),
        .cfg_rd_setup(cfg_rd_setup), .cfg_rd_pulse(cfg_rd_pulse),
        .cfg_cycle(cfg_cycle), .cfg_cap_on_rd(cfg_cap_on_rd), .cfg_err(cfg_err),
        .mem_addr(mem_addr), .mem_data_in(mem_data_in),
        .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic [23:0] addr;
        logic [7:0]  data;
        int          lat;
        int          cs_first;
        int          cs_len;
        int          rd_first;
        int          rd_len;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int checks = 0;
    int fails  = 0;

    function automatic logic [7:0] pat(logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
    endfunction

    function automatic int eff(int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int win_len(int s, int p, int c);
        int e;
        if (s >= eff(c)) return 0;
        e = s + eff(p);
        if (e > eff(c)) e = eff(c);
        return e - s;
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic wait_idle();
        do begin
            @(posedge clk);
            #1;
        end while (sb.size() != 0 || busy || req_ack);
    endtask

    task automatic set_cfg(int css, int csp, int rds, int rdp, int cyc, bit mode);
        wait_idle();
        cfg_cs_setup  = CNT_W'(css);
        cfg_cs_pulse  = CNT_W'(csp);
        cfg_rd_setup  = CNT_W'(rds);
        cfg_rd_pulse  = CNT_W'(rdp);
        cfg_cycle     = CNT_W'(cyc);
        cfg_cap_on_rd = mode;
    endtask

    // Driver: push expectation, hold the request until busy rises.
    task automatic issue(logic [23:0] a, string tag);
        exp_t e;
        int   sl;
        bit   prev;
        e.addr     = a;
        e.lat      = eff(int'(cfg_cycle));
        e.cs_len   = win_len(int'(cfg_cs_setup), int'(cfg_cs_pulse), int'(cfg_cycle));
        e.rd_len   = win_len(int'(cfg_rd_setup), int'(cfg_rd_pulse), int'(cfg_cycle));
        e.cs_first = (e.cs_len > 0) ? int'(cfg_cs_setup) : -1;
        e.rd_first = (e.rd_len > 0) ? int'(cfg_rd_setup) : -1;
        sl         = cfg_cap_on_rd ? e.rd_len : e.cs_len;
        e.data     = (sl == 0) ? 8'h00 : ((sl >= 2) ? pat(a) : 8'hEE);
        e.tag      = tag;
        sb.push_back(e);
        prev      = busy;
        req_valid = 1'b1;
        req_addr  = a;
        forever begin
            @(posedge clk);
            #1;
            if (busy && !prev) break;
            prev = busy;
        end
        req_valid = 1'b0;
    endtask

    // Device model: float (0xEE) until the selected strobe is low 2 clocks.
    int lowcnt = 0;
    always @(negedge clk) begin
        if (!(cfg_cap_on_rd ? mem_rd_n : mem_cs_n)) begin
            lowcnt++;
            mem_data_in = (lowcnt >= 2) ? pat(mem_addr) : 8'hEE;
        end else begin
            lowcnt = 0;
            mem_data_in = 8'hEE;
        end
    end

    // Monitor: measure strobe windows and compare on acknowledge.
    int idx = 0, cs_first = -1, cs_len = 0, rd_first = -1, rd_len = 0;
    logic [23:0] addr_seen = '0;
    bit addr_bad = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) begin
                if (idx == 0) addr_seen = mem_addr;
                else if (mem_addr != addr_seen) addr_bad = 1'b1;
                if (!mem_cs_n) begin
                    if (cs_len == 0) cs_first = idx;
                    cs_len++;
                end
                if (!mem_rd_n) begin
                    if (rd_len == 0) rd_first = idx;
                    rd_len++;
                end
                idx++;
            end else if (!mem_cs_n || !mem_rd_n) begin
                check(1'b0, "R3", "strobe low while idle", {mem_cs_n, mem_rd_n}, 3);
            end
            if (req_ack) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R4", "unexpected ack", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(ack_data == e.data, e.tag, "ack_data", ack_data, e.data);
                    check(idx == e.lat, "R4", "busy length", idx, e.lat);
                    check(!busy, "R4", "busy during ack", busy, 0);
                    check(cs_len == e.cs_len && cs_first == e.cs_first, "R3",
                          "select window first*256+len", cs_first * 256 + cs_len,
                          e.cs_first * 256 + e.cs_len);
                    check(rd_len == e.rd_len && rd_first == e.rd_first, "R3",
                          "read window first*256+len", rd_first * 256 + rd_len,
                          e.rd_first * 256 + e.rd_len);
                    check(addr_seen == e.addr && !addr_bad, "R2", "address",
                          int'(addr_seen), int'(e.addr));
                end
                idx = 0; cs_first = -1; cs_len = 0; rd_first = -1; rd_len = 0;
                addr_bad = 1'b0;
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check(mem_cs_n && mem_rd_n, "R1", "strobes", {mem_cs_n, mem_rd_n}, 3);
        check(!req_ack && !busy, "R1", "ack/busy", {req_ack, busy}, 0);
        check(!cfg_err, "R1", "cfg_err", cfg_err, 0);
        rst_n = 1'b1;

        // R5: read strobe inside select strobe
        set_cfg(0, 6, 1, 3, 8, 1'b1);
        issue(24'h12_34_56, "R5");
        // R5: select rises before read strobe
        set_cfg(1, 1, 2, 4, 7, 1'b1);
        issue(24'hA5_00_C3, "R5");
        // R6: select capture, read strobe short inside
        set_cfg(1, 5, 2, 2, 8, 1'b0);
        issue(24'h00_FF_10, "R6");
        // R6: read strobe outlasts select
        set_cfg(0, 3, 1, 5, 7, 1'b0);
        issue(24'h7E_81_02, "R6");
        // R7: read strobe cut at cycle end, capture there
        set_cfg(0, 2, 3, 10, 6, 1'b1);
        issue(24'h0F_0F_0F, "R7");
        // R6: one-clock select pulse returns the float value
        set_cfg(2, 1, 0, 4, 5, 1'b0);
        issue(24'h33_44_55, "R6");
        // R8: selected strobe never low
        set_cfg(0, 3, 9, 2, 6, 1'b1);
        issue(24'h99_88_77, "R8");
        wait_idle();
        check(!cfg_err, "R9", "cfg_err before zero use", cfg_err, 0);
        // R9: zero pulse runs as one clock and sets the flag
        set_cfg(0, 4, 1, 0, 4, 1'b1);
        issue(24'h01_02_03, "R9");
        wait_idle();
        check(cfg_err, "R9", "cfg_err after zero pulse", cfg_err, 1);
        // R2: back-to-back requests with request held high
        set_cfg(1, 4, 2, 3, 6, 1'b1);
        issue(24'h10_20_30, "R2");
        issue(24'h40_50_60, "R2");
        issue(24'h70_80_90, "R2");
        // R9: zero cycle count runs as one clock
        set_cfg(0, 1, 0, 1, 0, 1'b0);
        issue(24'hDE_AD_01, "R9");
        wait_idle();
        check(cfg_err, "R9", "cfg_err sticky", cfg_err, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule